// File: doc/BRIEF.md
# Indexed SMBus Configuration Target

This block is a slave-only SMBus target for a spread-spectrum clock companion device. It answers on one fixed 7-bit address. Through indexed block transfers it gives a host access to a small bank of 8-bit registers. Both bus lines are synchronized into the system clock domain and decoded there. The block finds START, repeated START and STOP conditions, shifts bytes in and out, and pulls the open-drain data line low to acknowledge. It keeps a register pointer that steps forward after every data byte.

Every transfer begins with a write-address phase that sets the register offset. A write then carries a byte count followed by data bytes. A read re-addresses the target for reading after a repeated START. The target then returns a byte count and then the register contents, until the host refuses a byte. Register 0 is the control register. While it is in pin-control mode, it mirrors the select pins and the frequency strap, and those pins drive the spread outputs. Once software sets the mode bit, the stored register fields drive the outputs instead.

The bus lines and the pins are plain signals: there is no streaming data path and no back-pressure. The host pacing on SCL is the only flow control.

Top module: `smb_cfg_target`

## Requirements
- R1: The target acknowledges the address bytes D4h (write) and D5h (read), which are 7-bit address 6Ah plus the direction bit. Any other address byte is not acknowledged. After it, the target stays off the data line and ignores all bytes until the next START.
- R2: A write transfer is sent in this order: D4h, offset N, count X, then data bytes. Each byte is acknowledged. Data bytes go to registers N, N+1, and so on. The count byte is acknowledged but does not limit how many data bytes are accepted.
- R3: A data byte is committed only when its acknowledge clock ends. A STOP in the middle of a byte leaves every earlier committed byte in place and discards the partial byte.
- R4: A read transfer is sent in this order: D4h, offset N, repeated START, D5h. The target then sends a count byte equal to NUM_REGS-N (or 00h when N is at or beyond NUM_REGS). It follows with registers N, N+1, and so on, each loaded when the host acknowledges the previous byte. A host NACK ends the transfer. Bytes are sent MSB first.
- R5: An offset at or beyond NUM_REGS (4 by default) reads as 00h. A write to such an offset is acknowledged and has no effect.
- R6: Control register 0 has this field layout. Bit 0 selects the mode: 0 = pins, 1 = software. Bit 1 is spread enable. Bit 2 is reserved. Bit 3 selects the frequency: 1 = 100 MHz. Bits 7, 6, 5 and 4 hold spread-select bits 0, 1, 2 and 3.
- R7: After reset the mode is pins and the stored enable is 1. In pin mode, register 0 reads as: bit 7 = 0, bit 6 = pin_sel[0], bit 5 = pin_sel[1], bit 4 = pin_sel[2], bit 3 = freq_strap, bit 2 = 0, bit 1 = 1, bit 0 = 0. The value follows the pins live.
- R8: In pin mode the outputs are spread_code = {pin_sel, 0}, spread_en = 1 and freq_100 = freq_strap.
- R9: In software mode the outputs come from register 0 and the pins have no effect. spread_code is {bit4, bit5, bit6, bit7}, spread_en is bit 1 and freq_100 is bit 3. Bit 2 always reads 0.
- R10: spread_center is 1 exactly when spread_code[3] is 1 (center spread). It is 0 when spread_code[3] is 0 (down spread).
- R11: sda_oe rises only while the synchronized SCL is low. It is 0 after reset and in the cycle after a STOP is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line as seen on the pad |
| sda_i | input | 1 | SMBus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| pin_sel | input | 3 | Spread select pins, bit 2 highest |
| freq_strap | input | 1 | Frequency strap, 1 = 100 MHz |
| spread_code | output | 4 | Resolved 4-bit spread code |
| spread_center | output | 1 | 1 = center spread, 0 = down spread |
| spread_en | output | 1 | Resolved spread enable |
| freq_100 | output | 1 | Resolved frequency select |

## Verification
The transfers use single-byte writes and reads at every implemented offset and at two offsets outside the bank. This separates correct indexing and the count value from simple echoing, and it tells in-range from out-of-range offsets. A multi-byte write followed by a four-byte read from offset 0 shows that the pointer advances and that the final NACK ends the transfer. A foreign address with trailing bytes, and a STOP in mid-byte, separate ignored or discarded traffic from committed writes. Pin-mode and software-mode settings are tried with different pin and strap values. This shows which source drives the outputs and the register-0 readback.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_RX_ACK, PH_TX, PH_TX_ACK, PH_IGNORE
  } phase_t;

  typedef enum logic [1:0] {
    ROLE_ADDR, ROLE_OFFS, ROLE_CNT, ROLE_DATA
  } role_t;

  localparam logic [6:0] DEV_ADDR = 7'h6A;
endpackage

// File: rtl/smbt_sync.sv
module smbt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] chain [0:STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= d;
      for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/smbt_regs.sv
module smbt_regs #(
  parameter int NUM_REGS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic [7:0]              wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [7:0]              rd_addr,
  output logic [7:0]              rd_data,
  input  logic [2:0]              pin_sel,
  input  logic                    freq_strap,
  output logic [3:0]              spread_code,
  output logic                    spread_center,
  output logic                    spread_en,
  output logic                    freq_100,
  output logic                    sw_mode,
  output logic [NUM_REGS*8-1:0]   bank_flat
);
  localparam int         IW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);
  localparam logic [7:0] RSVD_MASK = 8'hFB;

  logic [7:0] bank [NUM_REGS];
  logic [7:0] ctrl_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank[0] <= 8'h02;
      for (int i = 1; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (wr_stb && (wr_addr < NREG8)) begin
      if (wr_addr == 8'h00) bank[0] <= wr_data & RSVD_MASK;
      else                  bank[wr_addr[IW-1:0]] <= wr_data;
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
      assign bank_flat[g*8 +: 8] = bank[g];
    end
  endgenerate

  assign sw_mode   = bank[0][0];
  assign ctrl_view = sw_mode ? bank[0]
                   : {1'b0, pin_sel[0], pin_sel[1], pin_sel[2], freq_strap, 3'b010};

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr < NREG8)
      rd_data = (rd_addr == 8'h00) ? ctrl_view : bank[rd_addr[IW-1:0]];
  end

  always_comb begin
    if (sw_mode) begin
      spread_code = {bank[0][4], bank[0][5], bank[0][6], bank[0][7]};
      spread_en   = bank[0][1];
      freq_100    = bank[0][3];
    end else begin
      spread_code = {pin_sel, 1'b0};
      spread_en   = 1'b1;
      freq_100    = freq_strap;
    end
  end

  assign spread_center = spread_code[3];
endmodule

// File: rtl/smbt_link.sv
module smbt_link
  import smbt_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       scl_p,
  input  logic       sda_s,
  input  logic       sda_p,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_oe,
  output logic       start_det,
  output logic       stop_det,
  output phase_t     phase
);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  role_t      role;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] ptr;
  logic       is_read;
  logic       pend_wr;
  logic       scl_rise, scl_fall;
  logic [7:0] cnt_val;

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign cnt_val   = (ptr < NREG8) ? (NREG8 - ptr) : 8'h00;
  assign rd_addr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; role <= ROLE_ADDR; bitcnt <= '0; shreg <= '0;
      ptr <= '0; is_read <= 1'b0; pend_wr <= 1'b0; sda_oe <= 1'b0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        phase <= PH_RX; role <= ROLE_ADDR; bitcnt <= '0;
        sda_oe <= 1'b0; pend_wr <= 1'b0;
      end else if (stop_det) begin
        phase <= PH_IDLE; sda_oe <= 1'b0; pend_wr <= 1'b0;
      end else begin
        unique case (phase)
          PH_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              phase  <= PH_RX_ACK;
              sda_oe <= 1'b1;
              unique case (role)
                ROLE_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    is_read <= shreg[0];
                    role    <= ROLE_OFFS;
                  end else begin
                    sda_oe <= 1'b0;
                    phase  <= PH_IGNORE;
                  end
                end
                ROLE_OFFS: begin ptr <= shreg; role <= ROLE_CNT; end
                ROLE_CNT:  role <= ROLE_DATA;
                ROLE_DATA: pend_wr <= 1'b1;
              endcase
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              if (pend_wr) begin
                wr_stb  <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr + 8'd1;
                pend_wr <= 1'b0;
              end
              if (role == ROLE_OFFS && is_read) begin
                phase  <= PH_TX;
                shreg  <= cnt_val;
                sda_oe <= ~cnt_val[7];
              end else begin
                phase <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                phase  <= PH_TX_ACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              if (sda_s) begin
                phase <= PH_IGNORE;
              end else begin
                shreg <= rd_data;
                ptr   <= ptr + 8'd1;
              end
            end else if (scl_fall) begin
              phase  <= PH_TX;
              bitcnt <= '0;
              sda_oe <= ~shreg[7];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smbt_pkg::*;
#(
  parameter int NUM_REGS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] pin_sel,
  input  logic       freq_strap,
  output logic [3:0] spread_code,
  output logic       spread_center,
  output logic       spread_en,
  output logic       freq_100
);
  logic [1:0] bus_now, bus_old;
  logic       scl_s, sda_s, scl_p, sda_p;
  logic       start_det, stop_det;
  phase_t     link_phase;
  logic       wr_stb, sw_mode;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [NUM_REGS*8-1:0] bank_flat;

  smbt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_now), .q_prev(bus_old)
  );

  assign {scl_s, sda_s} = bus_now;
  assign {scl_p, sda_p} = bus_old;

  smbt_link #(.NUM_REGS(NUM_REGS)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s),
    .sda_p(sda_p), .rd_data(rd_data), .rd_addr(rd_addr), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe),
    .start_det(start_det), .stop_det(stop_det), .phase(link_phase)
  );

  smbt_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_sel(pin_sel), .freq_strap(freq_strap), .spread_code(spread_code),
    .spread_center(spread_center), .spread_en(spread_en), .freq_100(freq_100),
    .sw_mode(sw_mode), .bank_flat(bank_flat)
  );
endmodule

// File: rtl/smbt_chk.sv
module smbt_chk
  import smbt_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  sda_oe,
  input logic                  stop_det,
  input phase_t                phase,
  input logic                  sw_mode,
  input logic [2:0]            pin_sel,
  input logic                  freq_strap,
  input logic [3:0]            spread_code,
  input logic                  spread_en,
  input logic                  freq_100,
  input logic                  wr_stb,
  input logic [NUM_REGS*8-1:0] bank_flat
);
  // R11
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R1
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> !sda_oe);

  // R8
  pin_mode_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_mode |-> (spread_code == {pin_sel, 1'b0} && spread_en && freq_100 == freq_strap));

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(bank_flat));
endmodule

bind smb_cfg_target smbt_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .stop_det(stop_det),
  .phase(link_phase), .sw_mode(sw_mode), .pin_sel(pin_sel), .freq_strap(freq_strap),
  .spread_code(spread_code), .spread_en(spread_en), .freq_100(freq_100),
  .wr_stb(wr_stb), .bank_flat(bank_flat)
);

// File: tb/tb_smb_cfg_target.sv
module tb_smb_cfg_target;
  localparam int NREGS = 4;
  localparam int Q     = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_h = 1'b1;
  logic sda_line, sda_oe;
  logic [2:0] pin_sel = 3'b101;
  logic freq_strap = 1'b1;
  logic [3:0] spread_code;
  logic spread_center, spread_en, freq_100;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  smb_cfg_target #(.NUM_REGS(NREGS)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pin_sel(pin_sel), .freq_strap(freq_strap), .spread_code(spread_code),
    .spread_center(spread_center), .spread_en(spread_en), .freq_100(freq_100)
  );

  // offset, written byte, expected read value
  localparam logic [23:0] VEC [5] = '{24'h013C3C, 24'h02C3C3, 24'h035A5A,
                                      24'h057700, 24'hFF1100};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; scl = 1'b1; wq(); sda_h = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_h = 1'b1; wq(); scl = 1'b1; wq(); sda_h = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(); scl = 1'b1; wq(); sda_h = 1'b1; wq(); wq();
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    put_bits(b, 8);
    sda_h = 1'b1; wq(); scl = 1'b1; wq(); ack = !sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic get_byte(output logic [7:0] b, input logic host_ack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_h = 1'b1; wq(); scl = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl = 1'b0; wq();
    end
    sda_h = !host_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_h = 1'b1;
  endtask

  task automatic blk_write(input logic [7:0] off, input int n, input logic [31:0] d,
                           output logic all_ack);
    logic a;
    all_ack = 1'b1;
    bus_start();
    put_byte(8'hD4, a); all_ack &= a;
    put_byte(off, a);   all_ack &= a;
    put_byte(8'(n), a); all_ack &= a;
    for (int i = 0; i < n; i++) begin
      put_byte(d[31-8*i -: 8], a); all_ack &= a;
    end
    bus_stop();
  endtask

  task automatic blk_read(input logic [7:0] off, input int n, output logic [7:0] cnt,
                          output logic [31:0] d);
    logic a;
    logic [7:0] b;
    d = '0;
    bus_start();
    put_byte(8'hD4, a);
    put_byte(off, a);
    bus_rstart();
    put_byte(8'hD5, a);
    get_byte(cnt, 1'b1);
    for (int i = 0; i < n; i++) begin
      get_byte(b, i != n - 1);
      d = {d[23:0], b};
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ok, a;
    logic [7:0] cnt;
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7 R8 R10 R11: reset state in pin mode
    chk("R11 sda_oe after reset", sda_oe, 0);
    chk("R8 code from pins", spread_code, 4'hA);
    chk("R10 center spread", spread_center, 1);
    chk("R8 enable forced", spread_en, 1);
    chk("R8 freq from strap", freq_100, 1);

    // R7 R4: control readback reflects pins
    blk_read(8'h00, 1, cnt, d);
    chk("R4 count at offset 0", cnt, 8'h04);
    chk("R7 ctrl readback", d[7:0], 8'h5A);

    // R7 R8 R10: pins followed live
    pin_sel = 3'b011; freq_strap = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 code after pin change", spread_code, 4'h6);
    chk("R10 down spread", spread_center, 0);
    chk("R8 freq after strap change", freq_100, 0);
    blk_read(8'h00, 1, cnt, d);
    chk("R7 ctrl readback live", d[7:0], 8'h62);

    // R2 R4 R5: vector table
    foreach (VEC[k]) begin
      blk_write(VEC[k][23:16], 1, {VEC[k][15:8], 24'h0}, ok);
      chk("R2 R5 write acked", ok, 1);
      blk_read(VEC[k][23:16], 1, cnt, d);
      chk("R4 count", cnt, (VEC[k][23:16] < NREGS) ? 8'(NREGS - int'(VEC[k][23:16])) : 8'h00);
      chk("R4 R5 read data", d[7:0], VEC[k][7:0]);
    end

    // R2 R4: multi-byte write, four-byte read
    blk_write(8'h01, 3, 32'h11223300, ok);
    chk("R2 multi write acked", ok, 1);
    blk_read(8'h00, 4, cnt, d);
    chk("R4 count full bank", cnt, 8'h04);
    chk("R4 burst read", d, 32'h62112233);

    // R1: foreign address ignored
    bus_start();
    put_byte(8'hA0, a);
    chk("R1 foreign addr nack", a, 0);
    put_byte(8'h01, a);
    chk("R1 later byte ignored", a, 0);
    put_byte(8'hEE, a);
    bus_stop();
    blk_read(8'h01, 1, cnt, d);
    chk("R1 reg untouched", d[7:0], 8'h11);

    // R3: abort in mid-byte
    bus_start();
    put_byte(8'hD4, a); put_byte(8'h02, a); put_byte(8'h02, a);
    put_byte(8'h77, a);
    chk("R3 first byte acked", a, 1);
    put_bits(8'h99, 5);
    bus_stop();
    blk_read(8'h02, 2, cnt, d);
    chk("R3 committed and kept", d[15:0], 16'h7733);

    // R6 R9 R10: software mode
    blk_write(8'h00, 1, 32'h95000000, ok);
    chk("R9 code from register", spread_code, 4'h9);
    chk("R10 center in sw mode", spread_center, 1);
    chk("R9 enable from bit1", spread_en, 0);
    chk("R9 freq from bit3", freq_100, 0);
    blk_read(8'h00, 1, cnt, d);
    chk("R6 R9 readback reserved zero", d[7:0], 8'h91);
    pin_sel = 3'b000; freq_strap = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 pins ignored", {spread_code, freq_100}, 5'b10010);

    // R8: back to pin mode
    blk_write(8'h00, 1, 32'h00000000, ok);
    chk("R8 code pins again", spread_code, 4'h0);
    chk("R8 enable again", spread_en, 1);
    chk("R8 freq strap again", freq_100, 1);
    blk_read(8'h00, 1, cnt, d);
    chk("R7 readback pins again", d[7:0], 8'h0A);
    chk("R11 released at end", sda_oe, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule